// File: doc/BRIEF.md
# Monitor Channel Byte Transmitter

This block pushes a multi-byte message across a time-division monitor channel. Every frame carries one byte slot and two handshake bits: MX, which this block drives, and MR, which the far-end receiver drives. The frame timing comes from a one-cycle frame strobe. On each strobe the block samples MR for the frame that is ending and sets the byte and MX for the next frame. The receiver sets the pace. A new byte is shown with MX high for one frame. It is then held with MX low until MR shows that the receiver has taken it. The first byte of a message has an extra hold frame.

The host starts a message with a start pulse and supplies bytes over a valid/ready handshake. While more bytes follow, the host keeps the continue control `mxc` high. The host lowers `mxc` once the last byte has been taken. The transmitter then returns MX high and waits for the receiver's closing MR pattern before it raises the end-of-message flag. A receiver that leaves MR high in hold frames without ever acknowledging causes an abort. The block sets the abort flag and goes back to idle. Both flags are sticky until the host clears them.

Top module: `mon_chan_tx`

## Requirements
- R1: After reset and while idle, `mon_mx` is 1 and `mon_byte` is all ones (8'hFF). The block leaves idle only at a frame strobe where a start pulse has been seen since idle was entered and `tx_valid` is 1.
- R2: `mon_mx` and `mon_byte` change only on the clock edge at which `frame_stb` is 1.
- R3: The first byte of a message occupies at least three frames, with MX = 1, 0, 0. When the receiver answers at once, it occupies exactly three frames.
- R4: Every later byte is shown for one frame with MX = 1 and then held with MX = 0. When the receiver answers at once, it occupies exactly two frames.
- R5: A held byte counts as taken at the first hold-frame MR sample of 1 that meets two conditions: an MR sample of 0 was seen since the byte was shown, and the minimum hold count has been reached. Each MR sample of 0 stretches the hold by one frame.
- R6: `tx_ready` is 1 only in a `frame_stb` cycle, and a byte is taken when `tx_ready` and `tx_valid` are both 1. If the byte is taken with `mxc` = 1 and no data is valid, the taken byte stays on the channel with MX = 0 until data arrives.
- R7: If `mxc` is 0 when the byte is taken, the block drives MX = 1 with an all-ones byte. It sets `irq_mea` at the strobe that completes the MR sample sequence 0, 1, 1 while `mxc` is 0, and then returns to idle.
- R8: MR sampled as 1 in two consecutive hold frames with no 0 since the byte was shown, while `mxc` = 1, sets `irq_mab` and returns the block to idle outputs.
- R9: `irq_mea` (clear bit 0) and `irq_mab` (clear bit 1) stay set until a 1 on their own `irq_clr` bit. Clearing one flag leaves the other unchanged.
- R10: The end-of-message flag and the abort flag are never set by the same strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse marking the end of a channel frame |
| start | input | 1 | Start request pulse, taken while idle |
| tx_data | input | 8 | Next message byte from the host |
| tx_valid | input | 1 | `tx_data` holds a byte |
| tx_ready | output | 1 | Block takes `tx_data` this cycle if valid |
| mxc | input | 1 | Continue control: 1 while more bytes follow |
| mr_in | input | 1 | Receiver handshake bit for the current frame |
| irq_clr | input | 2 | Write-one-to-clear: bit 0 end flag, bit 1 abort flag |
| mon_byte | output | 8 | Byte driven in the current frame |
| mon_mx | output | 1 | Transmit handshake bit for the current frame |
| irq_mea | output | 1 | Sticky end-of-message acknowledge flag |
| irq_mab | output | 1 | Sticky abort flag |

## Verification
The assertions check the following on every cycle: the outputs move only on strobe edges, ready is confined to strobe cycles, both flags stay set until cleared, an end flag always lands on idle outputs with `mxc` low, and the two flags never rise together. Only the bench scenarios can show frame-by-frame pacing. These scenarios cover the three-frame first byte, the two-frame later bytes, hold frames stretched by MR low, extra hold frames when the host has no data, a slow closing pattern, and aborts on the first and a later byte, with each observed frame compared against a trace derived from message length, receiver delay and host gap.

// File: rtl/mon_tx_pkg.sv
package mon_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SHOW = 3'd1,
    ST_HOLD = 3'd2,
    ST_WAIT = 3'd3,
    ST_END  = 3'd4
  } mtx_state_e;

  localparam int IRQ_N   = 2;
  localparam int IRQ_END = 0;
  localparam int IRQ_ABT = 1;

endpackage

// File: rtl/mon_mr_hist.sv
module mon_mr_hist #(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             mr_in,
  output logic [DEPTH-1:0] hist
);

  logic [DEPTH-1:0] hist_q;
  logic [DEPTH-1:0] hist_d;

  // bit 0 is the most recent sample
  generate
    if (DEPTH == 1) begin : g_one
      always_comb hist_d = sample_en ? mr_in : hist_q;
    end else begin : g_many
      always_comb hist_d = sample_en ? {hist_q[DEPTH-2:0], mr_in} : hist_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '1;
    else        hist_q <= hist_d;
  end

  assign hist = hist_q;

endmodule

// File: rtl/mon_irq_flags.sv
module mon_irq_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags
);

  logic [N-1:0] flag_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      logic flag_d;
      // a set in the same cycle as a clear wins
      always_comb flag_d = set_i[i] | (flag_q[i] & ~clr_i[i]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[i] <= 1'b0;
        else        flag_q[i] <= flag_d;
      end
    end
  endgenerate

  assign flags = flag_q;

endmodule

// File: rtl/mon_tx_fsm.sv
module mon_tx_fsm
  import mon_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FIRST_HOLDS = 2,
  parameter int NEXT_HOLDS  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              mxc,
  input  logic              mr_in,
  input  logic              mr_prev,
  input  logic              mr_prev2,
  output logic [DATA_W-1:0] mon_byte,
  output logic              mon_mx,
  output logic              set_end,
  output logic              set_abt
);

  localparam int MAX_HOLDS = (FIRST_HOLDS > NEXT_HOLDS) ? FIRST_HOLDS : NEXT_HOLDS;
  localparam int CNT_W     = $clog2(MAX_HOLDS + 1);
  localparam logic [DATA_W-1:0] IDLE_BYTE = '1;
  localparam logic [CNT_W-1:0]  CNT_MAX   = CNT_W'(MAX_HOLDS);
  localparam logic [CNT_W-1:0]  NEED_1ST  = CNT_W'(FIRST_HOLDS);
  localparam logic [CNT_W-1:0]  NEED_NXT  = CNT_W'(NEXT_HOLDS);

  mtx_state_e        state_q, state_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              low_q, low_d;
  logic              first_q, first_d;
  logic              pend_q, pend_d;

  logic [CNT_W-1:0]  cnt_inc;
  logic              hold_ok;
  logic              accept;
  logic              abort;
  logic              end_ack;
  logic              take_ok;
  logic              take;

  // saturating count of completed hold frames for the current byte
  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign hold_ok = cnt_inc >= (first_q ? NEED_1ST : NEED_NXT);

  assign accept  = (state_q == ST_HOLD) && mr_in && low_q && hold_ok;
  assign abort   = (state_q == ST_HOLD) && mxc && mr_in && mr_prev
                   && !low_q && (cnt_q != '0);
  assign end_ack = (state_q == ST_END) && !mxc && !mr_prev2 && mr_prev && mr_in;

  assign take_ok = frame_stb && (((state_q == ST_IDLE) && pend_q) ||
                                 (accept && mxc) ||
                                 ((state_q == ST_WAIT) && mxc));
  assign take    = take_ok && tx_valid;
  assign tx_ready = take_ok;

  always_comb begin
    state_d = state_q;
    byte_d  = byte_q;
    cnt_d   = cnt_q;
    low_d   = low_q;
    first_d = first_q;
    pend_d  = pend_q;
    set_end = 1'b0;
    set_abt = 1'b0;

    if (state_q == ST_IDLE) begin
      if (take)       pend_d = 1'b0;
      else if (start) pend_d = 1'b1;
    end

    if (frame_stb) begin
      unique case (state_q)
        ST_IDLE: begin
          if (take) begin
            byte_d  = tx_data;
            first_d = 1'b1;
            cnt_d   = '0;
            low_d   = 1'b0;
            state_d = ST_SHOW;
          end
        end
        ST_SHOW: begin
          state_d = ST_HOLD;
          if (!mr_in) low_d = 1'b1;
        end
        ST_HOLD: begin
          if (abort) begin
            set_abt = 1'b1;
            state_d = ST_IDLE;
          end else if (accept) begin
            if (!mxc) begin
              state_d = ST_END;
            end else if (take) begin
              byte_d  = tx_data;
              first_d = 1'b0;
              cnt_d   = '0;
              low_d   = 1'b0;
              state_d = ST_SHOW;
            end else begin
              state_d = ST_WAIT;
            end
          end else begin
            cnt_d = cnt_inc;
            if (!mr_in) low_d = 1'b1;
          end
        end
        ST_WAIT: begin
          if (!mxc) begin
            state_d = ST_END;
          end else if (take) begin
            byte_d  = tx_data;
            first_d = 1'b0;
            cnt_d   = '0;
            low_d   = 1'b0;
            state_d = ST_SHOW;
          end
        end
        ST_END: begin
          if (end_ack) begin
            set_end = 1'b1;
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      byte_q  <= IDLE_BYTE;
      cnt_q   <= '0;
      low_q   <= 1'b0;
      first_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      byte_q  <= byte_d;
      cnt_q   <= cnt_d;
      low_q   <= low_d;
      first_q <= first_d;
      pend_q  <= pend_d;
    end
  end

  assign mon_mx   = (state_q == ST_IDLE) || (state_q == ST_SHOW) || (state_q == ST_END);
  assign mon_byte = ((state_q == ST_IDLE) || (state_q == ST_END)) ? IDLE_BYTE : byte_q;

endmodule

// File: rtl/mon_chan_tx.sv
module mon_chan_tx
  import mon_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FIRST_HOLDS = 2,
  parameter int NEXT_HOLDS  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              mxc,
  input  logic              mr_in,
  input  logic [IRQ_N-1:0]  irq_clr,
  output logic [DATA_W-1:0] mon_byte,
  output logic              mon_mx,
  output logic              irq_mea,
  output logic              irq_mab
);

  localparam int HIST_D = 2;

  logic [HIST_D-1:0] mr_hist;
  logic [IRQ_N-1:0]  irq_set;
  logic [IRQ_N-1:0]  irq_q;
  logic              set_end;
  logic              set_abt;

  mon_mr_hist #(.DEPTH(HIST_D)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (frame_stb),
    .mr_in     (mr_in),
    .hist      (mr_hist)
  );

  mon_tx_fsm #(
    .DATA_W      (DATA_W),
    .FIRST_HOLDS (FIRST_HOLDS),
    .NEXT_HOLDS  (NEXT_HOLDS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .start     (start),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .mxc       (mxc),
    .mr_in     (mr_in),
    .mr_prev   (mr_hist[0]),
    .mr_prev2  (mr_hist[1]),
    .mon_byte  (mon_byte),
    .mon_mx    (mon_mx),
    .set_end   (set_end),
    .set_abt   (set_abt)
  );

  always_comb begin
    irq_set          = '0;
    irq_set[IRQ_END] = set_end;
    irq_set[IRQ_ABT] = set_abt;
  end

  mon_irq_flags #(.N(IRQ_N)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (irq_set),
    .clr_i (irq_clr),
    .flags (irq_q)
  );

  assign irq_mea = irq_q[IRQ_END];
  assign irq_mab = irq_q[IRQ_ABT];

endmodule

// File: rtl/mon_chan_tx_chk.sv
module mon_chan_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_stb,
  input logic              mxc,
  input logic              tx_ready,
  input logic [1:0]        irq_clr,
  input logic [DATA_W-1:0] mon_byte,
  input logic              mon_mx,
  input logic              irq_mea,
  input logic              irq_mab
);

  assert_ready_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> frame_stb);

  assert_out_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(mon_mx) && $stable(mon_byte)));

  assert_end_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mea && !irq_clr[0]) |=> irq_mea);

  assert_abt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mab && !irq_clr[1]) |=> irq_mab);

  assert_end_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_mea) |-> (mon_mx && (mon_byte == '1) && !$past(mxc) && $past(frame_stb)));

  assert_abt_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_mab) |-> (mon_mx && (mon_byte == '1) && $past(mxc) && $past(frame_stb)));

  assert_flags_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(irq_mea) && $rose(irq_mab)));

endmodule

bind mon_chan_tx mon_chan_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_stb (frame_stb),
  .mxc       (mxc),
  .tx_ready  (tx_ready),
  .irq_clr   (irq_clr),
  .mon_byte  (mon_byte),
  .mon_mx    (mon_mx),
  .irq_mea   (irq_mea),
  .irq_mab   (irq_mab)
);

// File: tb/sim_mon_chan_tx.sv
`timescale 1ns/1ps
module sim_mon_chan_tx;

  logic       clk;
  logic       rst_n;
  logic       frame_stb;
  logic       start;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready;
  logic       mxc;
  logic       mr_in;
  logic [1:0] irq_clr;
  logic [7:0] mon_byte;
  logic       mon_mx;
  logic       irq_mea;
  logic       irq_mab;

  int checks   = 0;
  int failures = 0;

  logic       exp_mx [64];
  logic [7:0] exp_b  [64];
  logic       mr_s   [64];
  string      tag_s  [64];
  int         avail  [8];
  int         nfr;
  int         idx;
  int         cur_n;
  int         cur_msg;

  mon_chan_tx u0 (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .start(start),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .mxc(mxc),
    .mr_in(mr_in), .irq_clr(irq_clr), .mon_byte(mon_byte), .mon_mx(mon_mx),
    .irq_mea(irq_mea), .irq_mab(irq_mab)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=%0d exp=0", 1);
    finish_run();
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int msg, input int k);
    return 8'((msg * 29 + k * 67 + 3) % 255);
  endfunction

  task automatic push(input logic mx, input logic [7:0] b, input logic mr, input string t);
    exp_mx[nfr] = mx;
    exp_b[nfr]  = b;
    mr_s[nfr]   = mr;
    tag_s[nfr]  = t;
    nfr++;
  endtask

  // at a negedge: drive, strobe for one cycle, land on the next-next negedge
  task automatic do_strobe(input int j, input logic mr);
    logic took;
    mr_in    = mr;
    tx_valid = (idx < cur_n) && (j >= avail[(idx < 8) ? idx : 7]);
    tx_data  = bval(cur_msg, idx);
    frame_stb = 1'b1;
    #5;
    took = tx_ready && tx_valid;
    @(negedge clk);
    frame_stb = 1'b0;
    tx_valid  = 1'b0;
    if (took) idx++;
    if (idx >= cur_n) mxc = 1'b0;
    #5;
    chk("R6 ready outside strobe", int'(tx_ready), 0);
    @(negedge clk);
  endtask

  // normal message: n bytes, receiver stretch d, slow close e, host gap g
  task automatic build_msg(input int n, input int d, input int e, input int g, input int msg);
    nfr = 0;
    for (int i = 0; i < 8; i++) avail[i] = -2;
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      b = bval(msg, k);
      if (k == 1) avail[1] = nfr - 1;
      if (k == 0) begin
        push(1'b1, b, 1'b1, "R3 first show");
        push(1'b0, b, 1'b0, "R3 first hold");
        for (int s = 0; s < d; s++) push(1'b0, b, 1'b0, "R5 stretch");
        push(1'b0, b, 1'b1, "R3 first hold");
        if (n > 1) for (int s = 0; s < g; s++) push(1'b0, b, 1'b1, "R6 no data");
      end else begin
        push(1'b1, b, 1'b0, "R4 show");
        for (int s = 0; s < d; s++) push(1'b0, b, 1'b0, "R5 stretch");
        push(1'b0, b, 1'b1, "R4 hold");
      end
    end
    for (int s = 0; s < e; s++) push(1'b1, 8'hFF, 1'b0, "R7 closing");
    if (e > 0) push(1'b1, 8'hFF, 1'b1, "R7 closing");
    push(1'b1, 8'hFF, 1'b1, "R7 closing");
  endtask

  task automatic build_abort(input int ab, input int msg);
    nfr = 0;
    for (int i = 0; i < 8; i++) avail[i] = -2;
    for (int k = 0; k < ab; k++) begin
      if (k == 0) begin
        push(1'b1, bval(msg, 0), 1'b1, "R3 first show");
        push(1'b0, bval(msg, 0), 1'b0, "R3 first hold");
        push(1'b0, bval(msg, 0), 1'b1, "R3 first hold");
      end else begin
        push(1'b1, bval(msg, k), 1'b0, "R4 show");
        push(1'b0, bval(msg, k), 1'b1, "R4 hold");
      end
    end
    push(1'b1, bval(msg, ab), 1'b1, "R8 show");
    push(1'b0, bval(msg, ab), 1'b1, "R8 hold");
    push(1'b0, bval(msg, ab), 1'b1, "R8 hold");
  endtask

  task automatic run_frames(input int n, input int msg);
    cur_n   = n;
    cur_msg = msg;
    idx     = 0;
    mxc     = 1'b1;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    @(negedge clk);
    do_strobe(-1, 1'b1);
    for (int j = 0; j < nfr; j++) begin
      chk({tag_s[j], " mx"}, int'(mon_mx), int'(exp_mx[j]));
      chk({tag_s[j], " byte"}, int'(mon_byte), int'(exp_b[j]));
      chk("R7 no early end flag", int'(irq_mea), 0);
      do_strobe(j, mr_s[j]);
    end
  endtask

  task automatic pulse_clr(input logic [1:0] c);
    irq_clr = c;
    @(negedge clk);
    irq_clr = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; frame_stb = 1'b0; start = 1'b0; tx_data = 8'h00;
    tx_valid = 1'b0; mxc = 1'b1; mr_in = 1'b1; irq_clr = 2'b00;
    cur_n = 0; cur_msg = 0; idx = 0; nfr = 0;
    for (int i = 0; i < 8; i++) avail[i] = -2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 reset mx", int'(mon_mx), 1);
    chk("R1 reset byte", int'(mon_byte), 'hFF);
    chk("R9 reset end flag", int'(irq_mea), 0);
    chk("R9 reset abort flag", int'(irq_mab), 0);

    // R1: data valid but no start pulse
    cur_n = 1; cur_msg = 0; idx = 0;
    for (int s = 0; s < 3; s++) begin
      do_strobe(s, 1'b1);
      chk("R1 idle without start mx", int'(mon_mx), 1);
      chk("R1 idle without start byte", int'(mon_byte), 'hFF);
    end
    chk("R1 no byte taken without start", idx, 0);

    // R1: start pulse but no data
    start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    cur_n = 0; idx = 0;
    for (int s = 0; s < 2; s++) begin
      do_strobe(s, 1'b1);
      chk("R1 idle without data mx", int'(mon_mx), 1);
      chk("R1 idle without data byte", int'(mon_byte), 'hFF);
    end

    // sweep of normal messages
    begin
      int msg;
      msg = 1;
      for (int n = 1; n <= 4; n++)
        for (int d = 0; d <= 2; d++)
          for (int e = 0; e <= 1; e++)
            for (int g = 0; g <= 1; g++) begin
              if (!(g == 1 && n == 1)) begin
                build_msg(n, d, e, g, msg);
                run_frames(n, msg);
                chk("R7 end flag set", int'(irq_mea), 1);
                chk("R7 idle mx after end", int'(mon_mx), 1);
                chk("R7 idle byte after end", int'(mon_byte), 'hFF);
                chk("R10 no abort with end", int'(irq_mab), 0);
                chk("R6 all bytes taken", idx, n);
                if (n == 2 && d == 0) begin
                  pulse_clr(2'b10);
                  chk("R9 end flag kept on other clear", int'(irq_mea), 1);
                end
                pulse_clr(2'b01);
                chk("R9 end flag cleared", int'(irq_mea), 0);
                msg++;
              end
            end

      // aborts on first and second byte
      for (int ab = 0; ab <= 1; ab++) begin
        build_abort(ab, msg);
        run_frames(3, msg);
        chk("R8 abort flag set", int'(irq_mab), 1);
        chk("R8 idle mx after abort", int'(mon_mx), 1);
        chk("R8 idle byte after abort", int'(mon_byte), 'hFF);
        chk("R10 no end with abort", int'(irq_mea), 0);
        pulse_clr(2'b01);
        chk("R9 abort flag kept on other clear", int'(irq_mab), 1);
        pulse_clr(2'b10);
        chk("R9 abort flag cleared", int'(irq_mab), 0);
        msg++;
      end

      // a clean message still runs after an abort
      build_msg(2, 0, 0, 0, msg);
      run_frames(2, msg);
      chk("R7 end flag after recovery", int'(irq_mea), 1);
    end

    finish_run();
  end

endmodule